// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block produces the reset line for a processor subsystem. It holds reset at power-on and whenever a digital supply-good flag from an external comparator goes low. It lets reset go only once that flag has stayed high without a break for a fixed number of clock cycles. The analog voltage comparator and the open-drain pad stage are outside the block. It sees only the comparator's digital decision and drives a plain logic-level reset.

A watchdog runs alongside the supply monitor. Its input is the chip-select line, which the processor already toggles during normal work. Only a high-to-low transition on that line restarts the watchdog count. A rising edge or a steady level of either polarity leaves the count running. If no falling edge arrives within the selected period, the block enters reset and holds it for the same hold time that follows a brownout. After that it starts the watchdog again from zero. A two-bit control value, which the processor can rewrite, selects one of three period lengths or turns the watchdog off. A parameter sets whether the reset output is active high or active low.

Top module: `sup_wdog_reset`

## Requirements
- R1: While `por_n` is low, and after it rises for as long as `supply_ok` stays low, the reset output is active.
- R2: Reset is released only after `supply_ok` has been high without a break for `HOLD_CYC` cycles, plus at most three cycles of synchronizer and register latency.
- R3: When `supply_ok` goes low, the reset output is active within four clock cycles.
- R4: A low pulse on `supply_ok` of at least three cycles, arriving during the hold time, restarts the full hold count.
- R5: Each high-to-low transition on `wdi_cs` clears the watchdog count, so falling edges spaced closer than the period keep reset inactive.
- R6: If the watchdog is enabled and `wdi_cs` stays steadily high or steadily low longer than the selected period, the reset output goes active.
- R7: The selection `wd_sel` = 2'b00 chooses `WD_LONG` cycles, 2'b01 chooses `WD_MID`, and 2'b10 chooses `WD_SHORT`.
- R8: The selection `wd_sel` = 2'b11 disables the watchdog, so a steady `wdi_cs` never causes reset.
- R9: A watchdog expiry holds reset for `HOLD_CYC` cycles, with a tolerance of one cycle. The watchdog then counts again from zero after the release.
- R10: When `RST_ACTIVE_HIGH` is 1, the output is high while in reset. When it is 0, the output is low while in reset. The two variants are exact complements.
- R11: `wdi_cs` passes through two flip-flops before edge detection. A low-to-high transition does not restart the watchdog count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for all timers |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Digital supply-good flag from the external comparator (asynchronous) |
| wdi_cs | input | 1 | Chip-select line used as the watchdog kick (asynchronous) |
| wd_sel | input | 2 | Watchdog period select: 00 long, 01 mid, 10 short, 11 off |
| rst_out | output | 1 | Reset to the processor; its polarity is set by `RST_ACTIVE_HIGH` |

## Verification
The case that is hardest to reach from the ports is a watchdog expiry that runs into the restarted watchdog. This needs reset to be raised by the timer rather than by the supply, held for the full hold time, released, and then raised again one full period later. The watchdog counter is not visible, so the bench has to create a known starting point. It changes the period selection and the level of `wdi_cs` only while a short forced brownout holds reset. That fixes the count at zero at the moment of release. The bench then measures the reset pulse width and the next expiry in windows around the computed cycle. The rising-edge case is reached the same way. `wdi_cs` starts low during reset and rises halfway through the period, so an edge detector that also acted on rising edges would move the expiry well outside the window.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Watchdog period selection; the encoding is part of the port contract.
    typedef enum logic [1:0] {
        WD_SEL_LONG  = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_SHORT = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = d_async;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.meta <= RST_VAL;
            st_q.stab <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_sync = st_q.stab;

endmodule

// File: rtl/sup_hold_ctrl.sv
module sup_hold_ctrl #(
    parameter int unsigned HOLD_CYC = 2000
) (
    input  logic clk,
    input  logic por_n,
    input  logic sok_s,
    input  logic expire,
    output logic in_reset
);

    localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC + 1) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          active;
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sok_s || expire) begin
            // Supply loss or watchdog expiry: (re)enter reset, restart hold.
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt >= HOLD_LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_reset = st_q.active;

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int unsigned WD_LONG  = 16000,
    parameter int unsigned WD_MID   = 6000,
    parameter int unsigned WD_SHORT = 1500
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       enable,
    input  logic       wdi_s,
    input  logic [1:0] wd_sel,
    output logic       expire
);

    localparam int unsigned MAXP = max3(WD_LONG, WD_MID, WD_SHORT);
    localparam int unsigned CW   = $clog2(MAXP + 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(WD_LONG - 1);
    localparam logic [CW-1:0] LAST_MID   = CW'(WD_MID - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(WD_SHORT - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } wd_t;

    wd_t           st_d, st_q;
    logic [CW-1:0] last;
    logic          off;
    logic          fall;

    always_comb begin
        off  = 1'b0;
        last = LAST_LONG;
        case (wd_sel_e'(wd_sel))
            WD_SEL_LONG:  last = LAST_LONG;
            WD_SEL_MID:   last = LAST_MID;
            WD_SEL_SHORT: last = LAST_SHORT;
            default:      off  = 1'b1;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = wdi_s;
        fall      = st_q.prev & ~wdi_s;
        expire    = 1'b0;
        if (!enable || off) begin
            st_d.cnt = '0;
        end else if (fall) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= last) begin
            expire   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.prev <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sup_wdog_reset.sv
module sup_wdog_reset
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYC        = 2000,
    parameter int unsigned WD_LONG         = 16000,
    parameter int unsigned WD_MID          = 6000,
    parameter int unsigned WD_SHORT        = 1500,
    parameter bit          RST_ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_ok,
    input  logic       wdi_cs,
    input  logic [1:0] wd_sel,
    output logic       rst_out
);

    logic [1:0] sync_q;
    logic       sok_s;
    logic       wdi_s;
    logic       in_reset;
    logic       wd_expire;

    // bit 1: supply flag (clears low), bit 0: chip-select (clears high)
    sup_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async ({supply_ok, wdi_cs}),
        .q_sync  (sync_q)
    );

    assign sok_s = sync_q[1];
    assign wdi_s = sync_q[0];

    sup_hold_ctrl #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .por_n    (por_n),
        .sok_s    (sok_s),
        .expire   (wd_expire),
        .in_reset (in_reset)
    );

    sup_wdog #(
        .WD_LONG  (WD_LONG),
        .WD_MID   (WD_MID),
        .WD_SHORT (WD_SHORT)
    ) u_wdog (
        .clk    (clk),
        .por_n  (por_n),
        .enable (~in_reset),
        .wdi_s  (wdi_s),
        .wd_sel (wd_sel),
        .expire (wd_expire)
    );

    generate
        if (RST_ACTIVE_HIGH) begin : g_pol_high
            assign rst_out = in_reset;
        end else begin : g_pol_low
            assign rst_out = ~in_reset;
        end
    endgenerate

endmodule

// File: rtl/sup_wdog_reset_chk.sv
module sup_wdog_reset_chk #(
    parameter int unsigned HOLD_CYC = 2000
) (
    input logic       clk,
    input logic       por_n,
    input logic       sok_s,
    input logic       in_reset,
    input logic       expire,
    input logic [1:0] wd_sel
);

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                run_q <= '0;
        else if (in_reset && sok_s) run_q <= run_q + 1'b1;
        else                       run_q <= '0;
    end

    AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!por_n)
        !sok_s |=> in_reset); // R3

    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        $fell(in_reset) |-> ($past(run_q) == 32'(HOLD_CYC - 1))); // R4

    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!por_n)
        $fell(in_reset) |-> $past(sok_s)); // R2

    AST_EXPIRE_TO_RESET: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> in_reset); // R6

    AST_OFF_NO_EXPIRE: assert property (@(posedge clk) disable iff (!por_n)
        (wd_sel == 2'b11) |-> !expire); // R8

    AST_NO_EXPIRE_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        in_reset |-> !expire); // R9

endmodule

bind sup_wdog_reset sup_wdog_reset_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .sok_s    (sok_s),
    .in_reset (in_reset),
    .expire   (wd_expire),
    .wd_sel   (wd_sel)
);

// File: tb/tb_sup_wdog_reset.sv
module tb_sup_wdog_reset;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD  = 50;
    localparam int LLONG = 160;
    localparam int LMID  = 80;
    localparam int LSHRT = 40;
    localparam int WATCHDOG_CYC = 100000;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       wdi_cs = 1'b1;
    logic [1:0] wd_sel = 2'b11;
    logic       rst_out;
    logic       rst_hi;

    int checks = 0;
    int errors = 0;
    int pol_mismatch = 0;
    int cyc_count = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sup_wdog_reset #(.HOLD_CYC(HOLD), .WD_LONG(LLONG), .WD_MID(LMID),
        .WD_SHORT(LSHRT), .RST_ACTIVE_HIGH(1'b0)) dut (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .wdi_cs(wdi_cs),
        .wd_sel(wd_sel), .rst_out(rst_out));

    sup_wdog_reset #(.HOLD_CYC(HOLD), .WD_LONG(LLONG), .WD_MID(LMID),
        .WD_SHORT(LSHRT), .RST_ACTIVE_HIGH(1'b1)) dut_hi (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .wdi_cs(wdi_cs),
        .wd_sel(wd_sel), .rst_out(rst_hi));

    function automatic bit act();
        return (rst_out == 1'b0);
    endfunction

    // R10: complementary polarity variants, sampled away from the edge
    always @(negedge clk) begin
        cyc_count++;
        if (rst_hi !== ~rst_out) pol_mismatch++;
        if (cyc_count > WATCHDOG_CYC && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d",
                     cyc_count, WATCHDOG_CYC);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wait_release(output int n);
        n = 0;
        while (act() && n < 2000) begin
            cyc(1);
            n++;
        end
    endtask

    // Force a short brownout, set watchdog controls while reset holds, release.
    task automatic restart(input logic [1:0] sel, input logic wdi);
        int n;
        supply_ok = 1'b0;
        cyc(4);
        wd_sel = sel;
        wdi_cs = wdi;
        supply_ok = 1'b1;
        wait_release(n);
    endtask

    task automatic t_por();
        cyc(3);
        check(act(), "R1 reset during por", int'(rst_out), 0);
        por_n = 1'b1;
        cyc(100);
        check(act(), "R1 reset while supply low", int'(rst_out), 0);
    endtask

    task automatic t_release();
        supply_ok = 1'b1;
        cyc(HOLD - 4);
        check(act(), "R2 still in reset before hold ends", int'(rst_out), 0);
        cyc(10);
        check(!act(), "R2 released after hold", int'(rst_out), 1);
    endtask

    task automatic t_brownout();
        supply_ok = 1'b0;
        cyc(4);
        check(act(), "R3 reset on supply loss", int'(rst_out), 0);
        supply_ok = 1'b1;
        cyc(HOLD - 4);
        supply_ok = 1'b0;
        cyc(3);
        supply_ok = 1'b1;
        cyc(HOLD - 4);
        check(act(), "R4 glitch restarted hold", int'(rst_out), 0);
        cyc(10);
        check(!act(), "R4 released after full second hold", int'(rst_out), 1);
    endtask

    task automatic t_period(input logic [1:0] sel, input int per, input logic lvl, input string req);
        restart(sel, lvl);
        cyc(per - 4);
        check(!act(), {req, " no reset before period"}, int'(rst_out), 1);
        cyc(8);
        check(act(), {req, " reset after period"}, int'(rst_out), 0);
    endtask

    task automatic t_kick();
        int bad = 0;
        restart(2'b10, 1'b1);
        for (int i = 0; i < 10; i++) begin
            wdi_cs = 1'b1;
            for (int k = 0; k < 8; k++) begin cyc(1); if (act()) bad++; end
            wdi_cs = 1'b0;
            for (int k = 0; k < 8; k++) begin cyc(1); if (act()) bad++; end
        end
        check(bad == 0, "R5 kicks keep reset off", bad, 0);
        cyc(LSHRT);
        check(act(), "R5 reset after kicks stop", int'(rst_out), 0);
    endtask

    task automatic t_off();
        int bad = 0;
        restart(2'b11, 1'b1);
        for (int i = 0; i < 3 * LLONG; i++) begin cyc(1); if (act()) bad++; end
        check(bad == 0, "R8 disabled watchdog never resets", bad, 0);
    endtask

    task automatic t_expiry_hold();
        int n = 0;
        restart(2'b10, 1'b1);
        while (!act() && n < 1000) begin cyc(1); n++; end
        check(act(), "R9 expiry seen", int'(rst_out), 0);
        wait_release(n);
        check(n >= HOLD - 1 && n <= HOLD + 1, "R9 expiry reset width", n, HOLD);
        cyc(LSHRT - 4);
        check(!act(), "R9 watchdog restarted from zero", int'(rst_out), 1);
        cyc(8);
        check(act(), "R9 second expiry", int'(rst_out), 0);
    endtask

    task automatic t_rise_no_kick();
        restart(2'b10, 1'b0);
        cyc(LSHRT / 2);
        wdi_cs = 1'b1;
        cyc(LSHRT / 2 - 4);
        check(!act(), "R11 no reset before period", int'(rst_out), 1);
        cyc(8);
        check(act(), "R11 rising edge did not kick", int'(rst_out), 0);
    endtask

    initial begin
        t_por();
        t_release();
        t_brownout();
        t_period(2'b00, LLONG, 1'b1, "R7 long/R6 high");
        t_period(2'b01, LMID,  1'b0, "R7 mid/R6 low");
        t_period(2'b10, LSHRT, 1'b1, "R7 short");
        t_kick();
        t_off();
        t_expiry_hold();
        t_rise_no_kick();
        check(pol_mismatch == 0, "R10 polarity complement", pol_mismatch, 0);
        check(rst_hi == 1'b1 && rst_out == 1'b0, "R10 active levels", int'(rst_hi), 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule